// File: doc/BRIEF.md
# Serial Channel with Error-Stalled Receiver

This block is a single asynchronous serial channel driven through a byte-wide register port. Software sets the frame format and bit rate in two control registers, writes bytes to a transmit data register and reads received bytes from a receive data register. A status register reports buffer state and line errors. A level interrupt request combines the receive and transmit conditions, each with its own enable.

The bit clock is derived from the system clock. A prescaler of 10 or 30, a divide ratio of 16 or 64 and a power-of-two stage give the bit period. The receiver oversamples each bit 16 times and takes the middle sample. Once a parity, framing or overrun error has been recorded, the receiver discards every further character. This lasts until software writes a 0 to the error-flag-reset bit of control register A. Software therefore has to acknowledge every line error before it can receive again.

Top module: `sercom_channel`

## Requirements
- R1: Register offsets are control A at 0, control B at 2, status at 4, transmit data at 6 and receive data at 8. After reset control A reads 0x64, control B reads 0x00 and status reads 0x02. After reset rts_n is low, txd is high and irq is low.
- R2: Control A bit 4 is driven straight onto rts_n. Bits 6, 5, 4, 2, 1 and 0 read back as written. Bits 7 and 3 read as 0.
- R3: A transmitted frame has these parts in order: one low start bit; then the data bits, least significant first (8 when control A bit 2 is 1, 7 when it is 0); then a parity bit when control A bit 1 is 1; then one high stop bit, or two when control A bit 0 is 1. The line is high when idle.
- R4: Control B bit 4 set to 1 selects odd parity: the data bits and the parity bit together hold an odd number of ones. Set to 0, the count is even. This rule applies to transmit and to receive.
- R5: Status bit 1 (transmit empty) goes to 0 on a write to the transmit data register. It returns to 1 when the shifter takes the byte. The shifter takes a byte only when it is idle and control A bit 5 (transmitter enable) is 1.
- R6: A completed character is copied to the receive data register and sets status bit 7 (receive full). In 7-bit mode, bit 7 of the received byte reads 0. Reading the receive data register clears status bit 7.
- R7: If a character completes while status bit 7 is still set, status bit 6 (overrun) is set. The new character is dropped and the receive data register keeps the old byte.
- R8: A character whose parity does not match sets status bit 5. A character whose stop bit is sampled low sets status bit 4. In both cases the character is still delivered to the receive data register.
- R9: While any of status bits 6..4 is set, each completed character is dropped and leaves the registers unchanged. Writing control A with bit 3 at 0 clears all three error bits. Writing control A with bit 3 at 1 leaves them set.
- R10: The bit period in system clocks is (30 if control B bit 5 is 1, else 10) × (64 if control B bit 3 is 1, else 16) × 2^(control B bits 2..0). Control B bits 7 and 6 read as 0.
- R11: Status bit 3 (receive interrupt enable) and bit 0 (transmit interrupt enable) are read/write. irq = (bit 3 and (bit 7 or any of bits 6..4)) or (bit 0 and bit 1).
- R12: While control A bit 6 (receiver enable) is 0, incoming frames are ignored. While control A bit 5 is 0, txd stays high and a written byte waits in the transmit data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Register offset |
| wr_en | input | 1 | Write strobe, one cycle |
| rd_en | input | 1 | Read strobe, one cycle; a read of offset 8 clears receive full |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational on addr |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| rts_n | output | 1 | Request-to-send, active low |
| irq | output | 1 | Interrupt request, active high |

## Verification
A register write takes effect at the next clock edge. Reads are combinational, so the bench samples rdata just before the edge that applies the read strobe. The transmitter starts a frame at the first oversampling tick after the byte is taken, and each bit then lasts exactly one bit period. The bench therefore finds the falling start edge and samples txd at half a bit period, and then at whole bit periods after that. It also counts the clocks of a low run to check the divider. Receive flags are due about half a bit into the stop bit, plus two synchronizer cycles. The bench reads status only after the stop bit and one further idle bit. After a bad stop bit it waits a whole frame, so that a spurious start cannot land inside a later check.

// File: rtl/sercom_pkg.sv
package sercom_pkg;

    localparam int OVS      = 16;
    localparam int SUB_W    = $clog2(OVS);
    localparam int HALF     = OVS / 2;
    localparam int PRE_LO   = 10;
    localparam int PRE_HI   = 30;
    localparam int DR_STEP  = 4;
    localparam int SS_W     = 3;
    localparam int MAX_DIV  = PRE_HI * DR_STEP * (1 << ((1 << SS_W) - 1));
    localparam int DIV_W    = $clog2(MAX_DIV + 1);
    localparam int FRAME_MAX = 12;
    localparam int ADDR_W   = 4;

    localparam logic [ADDR_W-1:0] A_CTLA = 4'd0;
    localparam logic [ADDR_W-1:0] A_CTLB = 4'd2;
    localparam logic [ADDR_W-1:0] A_STAT = 4'd4;
    localparam logic [ADDR_W-1:0] A_TDR  = 4'd6;
    localparam logic [ADDR_W-1:0] A_RDR  = 4'd8;

    typedef struct packed {
        logic eight;
        logic par_en;
        logic par_odd;
        logic two_stop;
    } fmt_t;

    typedef struct packed {
        logic            pre_hi;
        logic            dr_hi;
        logic [SS_W-1:0] ss;
    } rate_t;

    typedef struct packed {
        logic re;
        logic te;
        logic rts;
        logic eight;
        logic par;
        logic stop2;
    } ctla_t;

    typedef struct packed {
        logic  odd;
        rate_t rate;
    } ctlb_t;

    localparam ctla_t CTLA_RST = '{re: 1'b1, te: 1'b1, rts: 1'b0,
                                   eight: 1'b1, par: 1'b0, stop2: 1'b0};

    typedef enum logic       {TX_IDLE, TX_RUN} tx_state_t;
    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_state_t;

    // clocks between oversampling ticks
    function automatic logic [DIV_W-1:0] tick_div(rate_t r);
        logic [DIV_W-1:0] base;
        base = r.pre_hi ? DIV_W'(PRE_HI) : DIV_W'(PRE_LO);
        if (r.dr_hi) base = base * DIV_W'(DR_STEP);
        return base << r.ss;
    endfunction

    function automatic logic data_parity(logic [7:0] d, logic eight);
        return eight ? ^d : ^d[6:0];
    endfunction

endpackage

// File: rtl/sercom_baud.sv
module sercom_baud
    import sercom_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  rate_t rate,
    output logic  tick
);
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] lim;

    assign lim = tick_div(rate) - DIV_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt >= lim) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + DIV_W'(1);
            tick <= 1'b0;
        end
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick) else $error("tick on adjacent cycles"); // R10

endmodule

// File: rtl/sercom_tx.sv
module sercom_tx
    import sercom_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       en,
    input  fmt_t       fmt,
    input  logic       pend,
    input  logic [7:0] data,
    output logic       take,
    output logic       txd
);
    tx_state_t              state;
    logic [FRAME_MAX-1:0]   shreg;
    logic [FRAME_MAX-1:0]   frame_v;
    logic [3:0]             par_pos;
    logic [3:0]             frame_len;
    logic [3:0]             left;
    logic [SUB_W-1:0]       sub;

    always_comb begin
        frame_v    = '1;
        frame_v[0] = 1'b0;
        for (int i = 0; i < 8; i++)
            if (fmt.eight || i < 7) frame_v[1+i] = data[i];
        par_pos = fmt.eight ? 4'd9 : 4'd8;
        if (fmt.par_en)
            frame_v[par_pos] = data_parity(data, fmt.eight) ^ fmt.par_odd;
        frame_len = par_pos + {3'b0, fmt.par_en} + 4'd1 + {3'b0, fmt.two_stop};
    end

    assign take = (state == TX_IDLE) && en && pend && tick;
    assign txd  = shreg[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= TX_IDLE;
            shreg <= '1;
            left  <= '0;
            sub   <= '0;
        end else begin
            case (state)
                TX_IDLE: if (take) begin
                    shreg <= frame_v;
                    left  <= frame_len;
                    sub   <= '0;
                    state <= TX_RUN;
                end
                TX_RUN: if (tick) begin
                    if (sub == SUB_W'(OVS - 1)) begin
                        sub   <= '0;
                        shreg <= {1'b1, shreg[FRAME_MAX-1:1]};
                        left  <= left - 4'd1;
                        if (left == 4'd1) state <= TX_IDLE;
                    end else begin
                        sub <= sub + SUB_W'(1);
                    end
                end
                default: state <= TX_IDLE;
            endcase
        end
    end

    AST_TX_START_LOW: assert property (@(posedge clk) disable iff (rst)
        take |=> !txd) else $error("no start bit after load"); // R3
    AST_TX_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
        (!en && state == TX_IDLE) |=> (txd && state == TX_IDLE)) else $error("disabled transmitter moved"); // R12

endmodule

// File: rtl/sercom_rx.sv
module sercom_rx
    import sercom_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       en,
    input  logic       eight,
    input  logic       par_en,
    input  logic       par_odd,
    input  logic       rxd,
    output logic       done,
    output logic [7:0] data,
    output logic       par_bad,
    output logic       stop_bad
);
    rx_state_t        state;
    logic [SUB_W-1:0] sub;
    logic [3:0]       idx;
    logic [9:0]       bits;
    logic [3:0]       nd;
    logic [3:0]       last_idx;

    assign nd       = eight ? 4'd8 : 4'd7;
    assign last_idx = nd + {3'b0, par_en};

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= RX_IDLE;
            sub      <= '0;
            idx      <= '0;
            bits     <= '0;
            done     <= 1'b0;
            data     <= '0;
            par_bad  <= 1'b0;
            stop_bad <= 1'b0;
        end else begin
            done <= 1'b0;
            if (!en) begin
                state <= RX_IDLE;
            end else if (tick) begin
                case (state)
                    RX_IDLE: if (!rxd) begin
                        state <= RX_START;
                        sub   <= '0;
                    end
                    RX_START: begin
                        if (sub == SUB_W'(HALF - 1)) begin
                            sub   <= '0;
                            idx   <= '0;
                            state <= rxd ? RX_IDLE : RX_BITS;
                        end else begin
                            sub <= sub + SUB_W'(1);
                        end
                    end
                    RX_BITS: begin
                        if (sub == SUB_W'(OVS - 1)) begin
                            sub       <= '0;
                            bits[idx] <= rxd;
                            if (idx == last_idx) begin
                                done     <= 1'b1;
                                data     <= eight ? bits[7:0] : {1'b0, bits[6:0]};
                                par_bad  <= par_en &&
                                            ((data_parity(bits[7:0], eight) ^ par_odd) != bits[nd]);
                                stop_bad <= !rxd;
                                state    <= RX_IDLE;
                            end else begin
                                idx <= idx + 4'd1;
                            end
                        end else begin
                            sub <= sub + SUB_W'(1);
                        end
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end

    AST_RX_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done) else $error("completion held"); // R6
    AST_RX_OFF_IDLE: assert property (@(posedge clk) disable iff (rst)
        !en |=> state == RX_IDLE) else $error("disabled receiver active"); // R12

endmodule

// File: rtl/sercom_channel.sv
module sercom_channel
    import sercom_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    input  logic              rxd,
    output logic              txd,
    output logic              rts_n,
    output logic              irq
);
    ctla_t      ctla;
    ctlb_t      ctlb;
    logic       rdrf, ovrn, perr, ferr, rie, tdre, tie;
    logic [7:0] tdr, rdr;
    logic       rxd_m, rxd_s;
    logic       tick, take;
    logic       rx_done, rx_par, rx_stop;
    logic [7:0] rx_data;
    fmt_t       fmt;

    logic wr_ctla, wr_ctlb, wr_stat, wr_tdr, rd_rdr, err_clr, errs, rdrf_left, rx_accept;

    assign wr_ctla   = wr_en && addr == A_CTLA;
    assign wr_ctlb   = wr_en && addr == A_CTLB;
    assign wr_stat   = wr_en && addr == A_STAT;
    assign wr_tdr    = wr_en && addr == A_TDR;
    assign rd_rdr    = rd_en && addr == A_RDR;
    assign err_clr   = wr_ctla && !wdata[3];
    assign errs      = ovrn | perr | ferr;
    assign rdrf_left = rdrf & ~rd_rdr;
    assign rx_accept = rx_done & ~errs;

    assign fmt = '{eight: ctla.eight, par_en: ctla.par, par_odd: ctlb.odd, two_stop: ctla.stop2};

    sercom_baud u_baud (
        .clk  (clk),
        .rst  (rst),
        .rate (ctlb.rate),
        .tick (tick)
    );

    sercom_tx u_tx (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .en   (ctla.te),
        .fmt  (fmt),
        .pend (~tdre),
        .data (tdr),
        .take (take),
        .txd  (txd)
    );

    sercom_rx u_rx (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .en       (ctla.re),
        .eight    (ctla.eight),
        .par_en   (ctla.par),
        .par_odd  (ctlb.odd),
        .rxd      (rxd_s),
        .done     (rx_done),
        .data     (rx_data),
        .par_bad  (rx_par),
        .stop_bad (rx_stop)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rxd_m <= 1'b1;
            rxd_s <= 1'b1;
            ctla  <= CTLA_RST;
            ctlb  <= '0;
            rie   <= 1'b0;
            tie   <= 1'b0;
            tdre  <= 1'b1;
            tdr   <= '0;
            rdr   <= '0;
            rdrf  <= 1'b0;
            ovrn  <= 1'b0;
            perr  <= 1'b0;
            ferr  <= 1'b0;
        end else begin
            rxd_m <= rxd;
            rxd_s <= rxd_m;
            if (wr_ctla)
                ctla <= '{re: wdata[6], te: wdata[5], rts: wdata[4],
                          eight: wdata[2], par: wdata[1], stop2: wdata[0]};
            if (wr_ctlb)
                ctlb <= '{odd: wdata[4],
                          rate: '{pre_hi: wdata[5], dr_hi: wdata[3], ss: wdata[2:0]}};
            if (wr_stat) begin
                rie <= wdata[3];
                tie <= wdata[0];
            end
            if (wr_tdr) begin
                tdr  <= wdata;
                tdre <= 1'b0;
            end else if (take) begin
                tdre <= 1'b1;
            end
            if (err_clr) begin
                ovrn <= 1'b0;
                perr <= 1'b0;
                ferr <= 1'b0;
            end
            rdrf <= rdrf_left;
            if (rx_accept) begin
                if (!rdrf_left) begin
                    rdr  <= rx_data;
                    rdrf <= 1'b1;
                    perr <= rx_par;
                    ferr <= rx_stop;
                end else begin
                    ovrn <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        unique case (addr)
            A_CTLA:  rdata = {1'b0, ctla.re, ctla.te, ctla.rts, 1'b0, ctla.eight, ctla.par, ctla.stop2};
            A_CTLB:  rdata = {2'b0, ctlb.rate.pre_hi, ctlb.odd, ctlb.rate.dr_hi, ctlb.rate.ss};
            A_STAT:  rdata = {rdrf, ovrn, perr, ferr, rie, 1'b0, tdre, tie};
            A_TDR:   rdata = tdr;
            A_RDR:   rdata = rdr;
            default: rdata = '0;
        endcase
    end

    assign rts_n = ctla.rts;
    assign irq   = (rie & (rdrf | errs)) | (tie & tdre);

    AST_RTS_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        wr_ctla |=> rts_n == $past(wdata[4])) else $error("rts_n not updated"); // R2
    AST_TDRE_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_tdr |=> !tdre) else $error("transmit empty after write"); // R5
    AST_RDRF_READ: assert property (@(posedge clk) disable iff (rst)
        (rd_rdr && !rx_done) |=> !rdrf) else $error("receive full survived read"); // R6
    AST_OVR_KEEP: assert property (@(posedge clk) disable iff (rst)
        (rx_done && rdrf && !rd_rdr && !errs) |=> (ovrn && $stable(rdr))) else $error("overrun mishandled"); // R7
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (errs && !err_clr) |=> ($stable(rdr) && !$rose(rdrf))) else $error("character taken during stall"); // R9
    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!rie && !tie) |-> !irq) else $error("irq with enables off"); // R11

endmodule

// File: tb/test_sercom_channel.sv
module test_sercom_channel;

    localparam logic [3:0] RA_CTLA = 4'd0;
    localparam logic [3:0] RA_CTLB = 4'd2;
    localparam logic [3:0] RA_STAT = 4'd4;
    localparam logic [3:0] RA_TDR  = 4'd6;
    localparam logic [3:0] RA_RDR  = 4'd8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] addr = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       rxd = 1'b1;
    logic       txd, rts_n, irq;

    int checks = 0;
    int errors = 0;
    int cur_bp = 160;
    bit finished = 0;

    sercom_channel i_sercom_channel (
        .clk   (clk),
        .rst   (rst),
        .addr  (addr),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .wdata (wdata),
        .rdata (rdata),
        .rxd   (rxd),
        .txd   (txd),
        .rts_n (rts_n),
        .irq   (irq)
    );

    always #10 clk = ~clk;

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    function automatic int bit_period(input logic pre_hi, input logic dr_hi, input int ss);
        return (pre_hi ? 30 : 10) * (dr_hi ? 64 : 16) * (1 << ss);
    endfunction

    task automatic make_frame(input logic [7:0] d, input logic eight, input logic par, input logic odd,
                              input logic stop2, input logic flip_par, input logic low_stop,
                              output logic [15:0] v, output int n);
        int nd;
        int k;
        int ones;
        logic p;
        nd = eight ? 8 : 7;
        v = '1;
        v[0] = 1'b0;
        ones = 0;
        for (int i = 0; i < nd; i++) begin
            v[1+i] = d[i];
            ones += int'(d[i]);
        end
        k = 1 + nd;
        if (par) begin
            p = ((ones % 2) == 1) ^ odd;
            v[k] = p ^ flip_par;
            k++;
        end
        v[k] = ~low_stop;
        k++;
        if (stop2) k++;
        n = k;
    endtask

    task automatic send_rx(input logic [15:0] v, input int n, input int tail);
        for (int i = 0; i < n; i++) begin
            rxd = v[i];
            repeat (cur_bp) @(negedge clk);
        end
        rxd = 1'b1;
        repeat (cur_bp * tail) @(negedge clk);
    endtask

    task automatic get_tx(input int n, output logic [15:0] v);
        int t;
        t = 0;
        v = '1;
        while (txd !== 1'b0 && t < 60000) begin
            @(negedge clk);
            t++;
        end
        repeat (cur_bp / 2) @(negedge clk);
        v[0] = txd;
        for (int i = 1; i < n; i++) begin
            repeat (cur_bp) @(negedge clk);
            v[i] = txd;
        end
    endtask

    task automatic tx_case(input logic [7:0] d, input logic [2:0] fa, input logic odd);
        logic [15:0] exp_v, got_v, mask;
        int n;
        wr(RA_CTLB, {3'b0, odd, 4'b0});
        wr(RA_CTLA, 8'h60 | {5'b0, fa});
        make_frame(d, fa[2], fa[1], odd, fa[0], 1'b0, 1'b0, exp_v, n);
        wr(RA_TDR, d);
        get_tx(n, got_v);
        mask = 16'((32'd1 << n) - 1);
        check(fa[1] ? "R4" : "R3", "tx frame", got_v & mask, exp_v & mask);
        repeat (cur_bp) @(negedge clk);
        check("R3", "idle line high", txd, 1'b1);
    endtask

    task automatic rx_case(input logic [7:0] d, input logic [2:0] fa, input logic odd);
        logic [15:0] v;
        logic [7:0] r;
        int n;
        wr(RA_CTLB, {3'b0, odd, 4'b0});
        wr(RA_CTLA, 8'h60 | {5'b0, fa});
        make_frame(d, fa[2], fa[1], odd, fa[0], 1'b0, 1'b0, v, n);
        send_rx(v, n, 1);
        rd(RA_STAT, r);
        check(fa[1] ? "R4" : "R6", "rx status full", r, 8'h82);
        rd(RA_RDR, r);
        check("R6", "rx data", r, fa[2] ? d : {1'b0, d[6:0]});
        rd(RA_STAT, r);
        check("R6", "rx full cleared by read", r, 8'h02);
    endtask

    task automatic baud_case(input logic pre_hi, input logic dr_hi, input int ss);
        int cnt;
        int t;
        wr(RA_CTLB, {2'b0, pre_hi, 1'b0, dr_hi, 3'(ss)});
        wr(RA_CTLA, 8'h64);
        cur_bp = bit_period(pre_hi, dr_hi, ss);
        wr(RA_TDR, 8'h00);
        t = 0;
        while (txd !== 1'b0 && t < 60000) begin
            @(negedge clk);
            t++;
        end
        cnt = 0;
        while (txd === 1'b0 && cnt < 100000) begin
            @(negedge clk);
            cnt++;
        end
        check("R10", "low run of 9 bits", cnt, 9 * cur_bp);
        repeat (2 * cur_bp) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired (all requirements)");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        logic [15:0] v;
        int n;
        int lows;
        void'($urandom(32'd20240611));

        repeat (5) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1", "rts_n after reset", rts_n, 1'b0);
        check("R1", "txd after reset", txd, 1'b1);
        check("R1", "irq after reset", irq, 1'b0);
        rd(RA_CTLA, r); check("R1", "control A reset", r, 8'h64);
        rd(RA_CTLB, r); check("R1", "control B reset", r, 8'h00);
        rd(RA_STAT, r); check("R1", "status reset", r, 8'h02);

        // R2: rts and control A readback
        wr(RA_CTLA, 8'h74);
        #1 check("R2", "rts_n high", rts_n, 1'b1);
        rd(RA_CTLA, r); check("R2", "control A readback", r, 8'h74);
        wr(RA_CTLA, 8'hEC);
        #1 check("R2", "rts_n low", rts_n, 1'b0);
        rd(RA_CTLA, r); check("R2", "bits 7 and 3 read 0", r, 8'h64);

        // R10: control B readback
        wr(RA_CTLB, 8'hFF);
        rd(RA_CTLB, r); check("R10", "control B readback", r, 8'h3F);
        wr(RA_CTLB, 8'h00);

        // R3 directed, then random formats
        tx_case(8'hA5, 3'b100, 1'b0);
        tx_case(8'h3C, 3'b111, 1'b1);
        for (int i = 0; i < 4; i++)
            tx_case(8'($urandom), 3'($urandom), 1'($urandom));

        // R5: transmit empty around a busy shifter
        wr(RA_CTLB, 8'h00);
        wr(RA_CTLA, 8'h64);
        wr(RA_TDR, 8'h81);
        repeat (40) @(negedge clk);
        rd(RA_STAT, r); check("R5", "byte taken, empty", r[1], 1'b1);
        wr(RA_TDR, 8'h7E);
        rd(RA_STAT, r); check("R5", "pending while busy", r[1], 1'b0);
        repeat (cur_bp * 22) @(negedge clk);
        rd(RA_STAT, r); check("R5", "second byte taken", r[1], 1'b1);

        // R6 directed and random receive
        rx_case(8'h5A, 3'b100, 1'b0);
        rx_case(8'hC3, 3'b000, 1'b0);
        for (int i = 0; i < 4; i++)
            rx_case(8'($urandom), 3'($urandom), 1'($urandom));

        // R8 parity error, R9 stall and clear
        wr(RA_CTLB, 8'h00);
        wr(RA_CTLA, 8'h66);
        make_frame(8'h96, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, v, n);
        send_rx(v, n, 1);
        rd(RA_STAT, r); check("R8", "parity error flagged", r, 8'hA2);
        rd(RA_RDR, r);  check("R8", "parity error data delivered", r, 8'h96);
        make_frame(8'h11, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, v, n);
        send_rx(v, n, 1);
        rd(RA_STAT, r); check("R9", "stalled, no new char", r, 8'h22);
        rd(RA_RDR, r);  check("R9", "stalled, data unchanged", r, 8'h96);
        wr(RA_CTLA, 8'h6E);
        rd(RA_STAT, r); check("R9", "bit3=1 keeps errors", r, 8'h22);
        wr(RA_CTLA, 8'h66);
        rd(RA_STAT, r); check("R9", "bit3=0 clears errors", r, 8'h02);
        send_rx(v, n, 1);
        rd(RA_STAT, r); check("R9", "receives after clear", r, 8'h82);
        rd(RA_RDR, r);  check("R9", "data after clear", r, 8'h11);

        // R8 framing error
        wr(RA_CTLA, 8'h64);
        make_frame(8'h42, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, v, n);
        send_rx(v, n, 12);
        rd(RA_STAT, r); check("R8", "framing error flagged", r, 8'h92);
        rd(RA_RDR, r);  check("R8", "framing data delivered", r, 8'h42);
        wr(RA_CTLA, 8'h64);

        // R7 overrun
        make_frame(8'h21, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, v, n);
        send_rx(v, n, 1);
        make_frame(8'hDE, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, v, n);
        send_rx(v, n, 1);
        rd(RA_STAT, r); check("R7", "overrun flagged", r, 8'hC2);
        rd(RA_RDR, r);  check("R7", "first byte kept", r, 8'h21);
        wr(RA_CTLA, 8'h64);

        // R11 interrupt
        wr(RA_STAT, 8'h09);
        rd(RA_STAT, r); check("R11", "enables readback", r, 8'h0B);
        #1 check("R11", "irq from transmit empty", irq, 1'b1);
        wr(RA_STAT, 8'h08);
        #1 check("R11", "irq quiet", irq, 1'b0);
        make_frame(8'h77, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, v, n);
        send_rx(v, n, 1);
        #1 check("R11", "irq from receive full", irq, 1'b1);
        rd(RA_RDR, r);
        #1 check("R11", "irq drops after read", irq, 1'b0);
        wr(RA_STAT, 8'h00);

        // R12 receiver off
        wr(RA_CTLA, 8'h24);
        make_frame(8'h99, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, v, n);
        send_rx(v, n, 1);
        rd(RA_STAT, r); check("R12", "receiver off ignores", r, 8'h02);
        rd(RA_RDR, r);  check("R12", "data unchanged when off", r, 8'h77);

        // R12 transmitter off
        wr(RA_CTLA, 8'h44);
        wr(RA_TDR, 8'h3C);
        lows = 0;
        for (int i = 0; i < cur_bp * 15; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) lows++;
        end
        check("R12", "txd held high", lows, 0);
        rd(RA_STAT, r); check("R12", "byte still pending", r, 8'h00);
        wr(RA_CTLA, 8'h64);
        make_frame(8'h3C, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, v, n);
        begin
            logic [15:0] got;
            get_tx(n, got);
            check("R12", "pending byte sent after enable", got & 16'h03FF, v & 16'h03FF);
        end
        repeat (cur_bp * 2) @(negedge clk);

        // R10 bit period
        baud_case(1'b0, 1'b0, 0);
        baud_case(1'b1, 1'b0, 1);
        baud_case(1'b0, 1'b1, 2);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule